// File: doc/BRIEF.md
# Write-Through Cache Controller with First-In Replacement

This block sits between a user-side read/write port and a slow main memory. It keeps a small fixed set of cache lines. Each line holds an address tag, a data word and a valid bit. A read whose address is cached completes in one cycle from the line store. A read that misses drives a main-memory read for a fixed, parameterized number of cycles. It then returns the fetched word and installs it as a new line. Every write is written through: the cache copy is updated at once (an existing line in place, or a newly allocated one) and main memory is written over a separate, parameterized number of cycles.

Hits are found in a single cycle through a one-bit presence array that spans the whole address space. When no line is free, the line that was installed earliest is evicted. A rewrite does not make a line younger. While main memory is being accessed, `busy` is high and the user side must hold off. Requests that arrive then are dropped. Read and write requests must not be raised together. If they are, a flag is raised and both requests are discarded.

Top module: `wtc_ctrl`

## Requirements
- R1: After reset, `busy`, `usr_rvalid`, `mem_rd` and `mem_wr` are low and no address is cached, so the first read of any address is a miss.
- R2: A read of a cached address taken while idle raises `usr_rvalid` in the next cycle with the cached word on `usr_rdata`, and `busy` stays low.
- R3: A read miss raises `busy` and `mem_rd` for exactly RD_LAT cycles with `mem_addr` equal to the request address. `usr_rvalid` rises in the first cycle after that, with the word that `mem_rdata` held in the last busy cycle on `usr_rdata`. A later read of that address hits.
- R4: A write raises `busy` and `mem_wr` for exactly WR_LAT cycles, with the request address on `mem_addr` and the request data on `mem_wdata`. A later read of that address hits and returns the written word.
- R5: A write to an address that is already cached rewrites that line in place and allocates no new line, so no other cached address is evicted.
- R6: When all LINES lines are valid and a new line is needed (read miss or write miss), the line installed earliest is evicted. Its address misses afterwards, and every other cached address still hits.
- R7: Rewriting a cached line does not change its age in the replacement order.
- R8: When `usr_rd` and `usr_wr` are both high, `rw_clash` is high in that cycle and both requests are ignored: no memory access, no `usr_rvalid`, no change to cache or memory.
- R9: Requests presented while `busy` is high are ignored. The running access keeps its address and length, and a write offered then never reaches memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usr_rd | input | 1 | User read request (one-cycle pulse) |
| usr_wr | input | 1 | User write request (one-cycle pulse) |
| usr_addr | input | ADDR_W | Request address |
| usr_wdata | input | DATA_W | Write data |
| usr_rdata | output | DATA_W | Read data, valid with usr_rvalid |
| usr_rvalid | output | 1 | Read result valid pulse |
| busy | output | 1 | Main memory access in progress |
| rw_clash | output | 1 | Read and write requested together |
| mem_rd | output | 1 | Main memory read strobe |
| mem_wr | output | 1 | Main memory write strobe |
| mem_addr | output | ADDR_W | Main memory address |
| mem_wdata | output | DATA_W | Main memory write data |
| mem_rdata | input | DATA_W | Main memory read data |

## Verification
The bench fills every line, rewrites the oldest line and then forces evictions. A design that refreshed age on a rewrite, or that evicted the newest line, would hit where a miss is expected and would skip the memory read. A read of an address that was written through and then evicted must return the new memory word. A controller that sourced read data from a stale cache register, or that skipped the memory write, returns the old value. A collided read/write and a write issued during a miss must leave memory untouched, and the miss must keep its address and RD_LAT length. A design that accepted either request would show a `mem_wr` strobe, a stretched busy window or a cached value that should not exist.

// File: rtl/wtc_pkg.sv
`timescale 1ns/1ps
package wtc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RDMEM = 2'd1,
    ST_WRMEM = 2'd2
  } wtc_state_e;
endpackage

// File: rtl/wtc_presence.sv
`timescale 1ns/1ps
module wtc_presence #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic              clr_en,
  input  logic [ADDR_W-1:0] clr_addr,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              look_hit
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] bits_q, bits_d;

  always_comb begin
    bits_d = bits_q;
    if (clr_en) bits_d[clr_addr] = 1'b0;
    if (set_en) bits_d[set_addr] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_d;
  end

  assign look_hit = bits_q[look_addr];

  // R6: a new line is only installed for an absent address, and an evicted one was present
  assert_set_absent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !bits_q[set_addr]);
  assert_clr_present_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> bits_q[clr_addr]);
endmodule

// File: rtl/wtc_repl.sv
`timescale 1ns/1ps
module wtc_repl #(
  parameter int LINES = 4,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  output logic [IDX_W-1:0] victim_idx,
  output logic             full
);
  localparam int CNT_W = $clog2(LINES + 1);

  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign full       = (cnt_q == CNT_W'(LINES));
  assign victim_idx = ptr_q;

  always_comb begin
    ptr_d = ptr_q;
    cnt_d = cnt_q;
    if (alloc_en) begin
      ptr_d = (ptr_q == IDX_W'(LINES - 1)) ? '0 : ptr_q + 1'b1;
      if (!full) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      cnt_q <= cnt_d;
    end
  end

  // R6: occupancy never exceeds the line count, and a full cache stays full
  assert_occupancy_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(LINES));
  assert_full_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> full);
endmodule

// File: rtl/wtc_lines.sv
`timescale 1ns/1ps
module wtc_lines #(
  parameter int LINES  = 4,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              match_any,
  output logic [IDX_W-1:0]  match_idx,
  output logic [DATA_W-1:0] match_data,
  input  logic [IDX_W-1:0]  vic_idx,
  output logic [ADDR_W-1:0] vic_tag
);
  logic [ADDR_W-1:0] tag_q  [LINES];
  logic [ADDR_W-1:0] tag_d  [LINES];
  logic [DATA_W-1:0] data_q [LINES];
  logic [DATA_W-1:0] data_d [LINES];
  logic [LINES-1:0]  vld_q, vld_d;
  logic [LINES-1:0]  match_vec;

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign match_vec[g] = vld_q[g] && (tag_q[g] == look_addr);
  end

  always_comb begin
    match_idx  = '0;
    match_data = '0;
    for (int i = 0; i < LINES; i++) begin
      if (match_vec[i]) begin
        match_idx  = match_idx | IDX_W'(i);
        match_data = match_data | data_q[i];
      end
    end
  end

  assign match_any = |match_vec;
  assign vic_tag   = tag_q[vic_idx];

  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      tag_d[i]  = tag_q[i];
      data_d[i] = data_q[i];
    end
    vld_d = vld_q;
    if (wr_en) begin
      tag_d[wr_idx]  = wr_tag;
      data_d[wr_idx] = wr_data;
      vld_d[wr_idx]  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < LINES; i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      vld_q <= vld_d;
      for (int i = 0; i < LINES; i++) begin
        tag_q[i]  <= tag_d[i];
        data_q[i] <= data_d[i];
      end
    end
  end

  // R5: an address is held by at most one line
  assert_single_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));
endmodule

// File: rtl/wtc_ctrl.sv
`timescale 1ns/1ps
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int LINES  = 4,
  parameter int RD_LAT = 3,
  parameter int WR_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              usr_rd,
  input  logic              usr_wr,
  input  logic [ADDR_W-1:0] usr_addr,
  input  logic [DATA_W-1:0] usr_wdata,
  output logic [DATA_W-1:0] usr_rdata,
  output logic              usr_rvalid,
  output logic              busy,
  output logic              rw_clash,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int MAXL  = (RD_LAT > WR_LAT) ? RD_LAT : WR_LAT;
  localparam int CNT_W = $clog2(MAXL + 1);
  localparam int BL_W  = $clog2(MAXL + 2);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  wtc_state_e        state_q, state_d;
  logic [CNT_W-1:0]  rd_cnt_q, rd_cnt_d, wr_cnt_q, wr_cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [DATA_W-1:0] cache_q, cache_d, memq_q, memq_d;
  logic              from_mem_q, from_mem_d, mem_vld_q, mem_vld_d;
  logic              rvalid_q, rvalid_d;

  logic              idle, acc_rd, acc_wr, hit, miss, rd_done;
  logic              pres_hit, line_hit;
  logic [IDX_W-1:0]  line_idx, vic_idx, wr_idx;
  logic [DATA_W-1:0] line_data, wr_data;
  logic [ADDR_W-1:0] wr_tag, vic_tag;
  logic              line_wr, alloc, full;

  assign idle     = (state_q == ST_IDLE);
  assign rw_clash = usr_rd && usr_wr;
  assign acc_rd   = idle && usr_rd && !usr_wr;
  assign acc_wr   = idle && usr_wr && !usr_rd;
  assign hit      = pres_hit;
  assign miss     = !hit;
  assign rd_done  = (state_q == ST_RDMEM) && (rd_cnt_q == '0);

  // line store update: write at request time, read fill at end of fetch
  always_comb begin
    line_wr = 1'b0;
    alloc   = 1'b0;
    wr_idx  = vic_idx;
    wr_tag  = usr_addr;
    wr_data = usr_wdata;
    if (acc_wr) begin
      line_wr = 1'b1;
      alloc   = miss;
      wr_idx  = hit ? line_idx : vic_idx;
    end else if (rd_done) begin
      line_wr = 1'b1;
      alloc   = 1'b1;
      wr_tag  = addr_q;
      wr_data = mem_rdata;
    end
  end

  wtc_presence #(.ADDR_W(ADDR_W)) u_pres (
    .clk(clk), .rst_n(rst_i_n),
    .set_en(alloc), .set_addr(wr_tag),
    .clr_en(alloc && full), .clr_addr(vic_tag),
    .look_addr(usr_addr), .look_hit(pres_hit)
  );

  wtc_repl #(.LINES(LINES)) u_repl (
    .clk(clk), .rst_n(rst_i_n),
    .alloc_en(alloc), .victim_idx(vic_idx), .full(full)
  );

  wtc_lines #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lines (
    .clk(clk), .rst_n(rst_i_n),
    .wr_en(line_wr), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data),
    .look_addr(usr_addr), .match_any(line_hit), .match_idx(line_idx),
    .match_data(line_data), .vic_idx(vic_idx), .vic_tag(vic_tag)
  );

  always_comb begin
    state_d    = state_q;
    rd_cnt_d   = rd_cnt_q;
    wr_cnt_d   = wr_cnt_q;
    addr_d     = addr_q;
    wdata_d    = wdata_q;
    cache_d    = cache_q;
    memq_d     = memq_q;
    from_mem_d = from_mem_q;
    mem_vld_d  = mem_vld_q;
    rvalid_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (acc_rd && hit) begin
          cache_d    = line_data;
          from_mem_d = 1'b0;
          rvalid_d   = 1'b1;
        end else if (acc_rd) begin
          state_d    = ST_RDMEM;
          rd_cnt_d   = CNT_W'(RD_LAT - 1);
          addr_d     = usr_addr;
          from_mem_d = 1'b1;
          mem_vld_d  = 1'b0;
        end else if (acc_wr) begin
          state_d  = ST_WRMEM;
          wr_cnt_d = CNT_W'(WR_LAT - 1);
          addr_d   = usr_addr;
          wdata_d  = usr_wdata;
        end
      end
      ST_RDMEM: begin
        if (rd_cnt_q == '0) begin
          state_d   = ST_IDLE;
          memq_d    = mem_rdata;
          mem_vld_d = 1'b1;
          rvalid_d  = 1'b1;
        end else begin
          rd_cnt_d = rd_cnt_q - 1'b1;
        end
      end
      ST_WRMEM: begin
        if (wr_cnt_q == '0) state_d = ST_IDLE;
        else                wr_cnt_d = wr_cnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q    <= ST_IDLE;
      rd_cnt_q   <= '0;
      wr_cnt_q   <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
      cache_q    <= '0;
      memq_q     <= '0;
      from_mem_q <= 1'b0;
      mem_vld_q  <= 1'b0;
      rvalid_q   <= 1'b0;
    end else begin
      state_q    <= state_d;
      rd_cnt_q   <= rd_cnt_d;
      wr_cnt_q   <= wr_cnt_d;
      addr_q     <= addr_d;
      wdata_q    <= wdata_d;
      cache_q    <= cache_d;
      memq_q     <= memq_d;
      from_mem_q <= from_mem_d;
      mem_vld_q  <= mem_vld_d;
      rvalid_q   <= rvalid_d;
    end
  end

  assign busy       = !idle;
  assign mem_rd     = (state_q == ST_RDMEM);
  assign mem_wr     = (state_q == ST_WRMEM);
  assign mem_addr   = addr_q;
  assign mem_wdata  = wdata_q;
  assign usr_rvalid = rvalid_q;
  assign usr_rdata  = (from_mem_q && mem_vld_q) ? memq_q : cache_q;

  // busy-window length, for the access-time checks
  logic [BL_W-1:0] blen_q;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)  blen_q <= '0;
    else if (busy) blen_q <= blen_q + 1'b1;
    else           blen_q <= '0;
  end

  // R2: presence array and line tags agree on every lookup
  assert_presence_matches_lines_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    pres_hit == line_hit);
  // R3: read fetch lasts exactly RD_LAT cycles
  assert_read_window_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(mem_rd) |-> (blen_q == BL_W'(RD_LAT)));
  // R4: write-through lasts exactly WR_LAT cycles
  assert_write_window_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(mem_wr) |-> (blen_q == BL_W'(WR_LAT)));
  // R8: a collided request starts nothing
  assert_clash_dropped_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rw_clash && !busy) |=> (!busy && !usr_rvalid));
  // R9: the running access keeps its address
  assert_busy_addr_held_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    busy |=> (!busy || $stable(mem_addr)));
endmodule

// File: tb/wtc_ctrl_test.sv
`timescale 1ns/1ps
module wtc_ctrl_test;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int LINES  = 4;
  localparam int RD_LAT = 3;
  localparam int WR_LAT = 2;
  localparam int NVEC   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic usr_rd = 1'b0, usr_wr = 1'b0;
  logic [ADDR_W-1:0] usr_addr = '0;
  logic [DATA_W-1:0] usr_wdata = '0;
  logic [DATA_W-1:0] usr_rdata, mem_wdata, mem_rdata;
  logic usr_rvalid, busy, rw_clash, mem_rd, mem_wr;
  logic [ADDR_W-1:0] mem_addr;

  int checks = 0;
  int fails  = 0;

  logic [DATA_W-1:0] bmem    [1<<ADDR_W];
  logic [DATA_W-1:0] ref_mem [1<<ADDR_W];

  always #10 clk = ~clk;

  wtc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES),
             .RD_LAT(RD_LAT), .WR_LAT(WR_LAT)) uut (
    .clk(clk), .rst_n(rst_n), .usr_rd(usr_rd), .usr_wr(usr_wr),
    .usr_addr(usr_addr), .usr_wdata(usr_wdata), .usr_rdata(usr_rdata),
    .usr_rvalid(usr_rvalid), .busy(busy), .rw_clash(rw_clash),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // main memory model
  assign mem_rdata = bmem[mem_addr];
  always @(posedge clk) if (mem_wr) bmem[mem_addr] <= mem_wdata;

  // {write, addr, wdata, expect_hit}
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b0, 6'd5,  8'h00, 1'b0},  // first read misses (R1)
    {1'b0, 6'd5,  8'h00, 1'b1},  // hit
    {1'b1, 6'd9,  8'hA1, 1'b0},  // write miss fills a line
    {1'b0, 6'd9,  8'h00, 1'b1},  // written word hits
    {1'b0, 6'd12, 8'h00, 1'b0},
    {1'b0, 6'd20, 8'h00, 1'b0},  // now full: 5,9,12,20
    {1'b1, 6'd5,  8'h5C, 1'b0},  // rewrite in place (R5, R7)
    {1'b0, 6'd33, 8'h00, 1'b0},  // evicts 5 though rewritten
    {1'b0, 6'd5,  8'h00, 1'b0},  // 5 gone, evicts 9
    {1'b0, 6'd12, 8'h00, 1'b1},
    {1'b0, 6'd9,  8'h00, 1'b0},  // evicts 12
    {1'b0, 6'd12, 8'h00, 1'b0},  // evicts 20
    {1'b0, 6'd33, 8'h00, 1'b1},
    {1'b1, 6'd40, 8'hC4, 1'b0},  // write miss evicts 33
    {1'b0, 6'd33, 8'h00, 1'b0},
    {1'b0, 6'd40, 8'h00, 1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, input bit exp_hit, input string req);
    int n;
    bit strobe_ok;
    @(negedge clk);
    usr_rd = 1'b1; usr_addr = a;
    @(negedge clk);
    usr_rd = 1'b0;
    n = 0; strobe_ok = 1'b1;
    while (busy && n < 50) begin
      if (!mem_rd || mem_addr != a) strobe_ok = 1'b0;
      n++;
      @(negedge clk);
    end
    check((n != 0) == !exp_hit, {req, " hit/miss"}, n, exp_hit ? 0 : RD_LAT);
    if (!exp_hit) begin
      check(n == RD_LAT, "R3 read busy length", n, RD_LAT);
      check(strobe_ok, "R3 mem_rd/mem_addr during fetch", 0, 1);
    end
    check(usr_rvalid == 1'b1, exp_hit ? "R2 rvalid" : "R3 rvalid", usr_rvalid, 1);
    check(usr_rdata == ref_mem[a], exp_hit ? "R2 rdata" : "R3 rdata", usr_rdata, ref_mem[a]);
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    int n;
    bit strobe_ok;
    @(negedge clk);
    usr_wr = 1'b1; usr_addr = a; usr_wdata = d;
    @(negedge clk);
    usr_wr = 1'b0;
    n = 0; strobe_ok = 1'b1;
    while (busy && n < 50) begin
      if (!mem_wr || mem_addr != a || mem_wdata != d) strobe_ok = 1'b0;
      n++;
      @(negedge clk);
    end
    ref_mem[a] = d;
    check(n == WR_LAT, "R4 write busy length", n, WR_LAT);
    check(strobe_ok, "R4 mem_wr/addr/data", 0, 1);
    check(bmem[a] == d, "R4 memory written", bmem[a], d);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < (1<<ADDR_W); i++) begin
      bmem[i]    = DATA_W'(i * 7 + 3);
      ref_mem[i] = DATA_W'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(usr_rvalid == 1'b0, "R1 rvalid", usr_rvalid, 0);
    check(mem_rd == 1'b0 && mem_wr == 1'b0, "R1 mem strobes", {mem_rd, mem_wr}, 0);

    // table walk: R2..R7
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][15])
        do_write(VEC[v][14:9], VEC[v][8:1]);
      else
        do_read(VEC[v][14:9], VEC[v][0], VEC[v][0] ? "R2" : "R6");
    end

    // R8: read and write together
    @(negedge clk);
    usr_rd = 1'b1; usr_wr = 1'b1; usr_addr = 6'd50; usr_wdata = 8'hFF;
    #1;
    check(rw_clash == 1'b1, "R8 clash flag", rw_clash, 1);
    @(negedge clk);
    usr_rd = 1'b0; usr_wr = 1'b0;
    check(busy == 1'b0 && mem_wr == 1'b0 && mem_rd == 1'b0, "R8 no access", busy, 0);
    check(usr_rvalid == 1'b0, "R8 no rvalid", usr_rvalid, 0);
    check(bmem[50] == ref_mem[50], "R8 memory untouched", bmem[50], ref_mem[50]);
    do_read(6'd50, 1'b0, "R8");

    // R9: write offered during a read fetch
    begin
      int n;
      bit ok;
      @(negedge clk);
      usr_rd = 1'b1; usr_addr = 6'd41;
      @(negedge clk);
      usr_rd = 1'b0; usr_wr = 1'b1; usr_addr = 6'd60; usr_wdata = 8'hAA;
      n = 0; ok = 1'b1;
      while (busy && n < 50) begin
        if (mem_wr || mem_addr != 6'd41) ok = 1'b0;
        n++;
        @(negedge clk);
        usr_wr = 1'b0;
      end
      check(n == RD_LAT, "R9 fetch length kept", n, RD_LAT);
      check(ok, "R9 no write, address kept", 0, 1);
      check(usr_rvalid && usr_rdata == ref_mem[41], "R9 read result", usr_rdata, ref_mem[41]);
      @(negedge clk);
      check(busy == 1'b0, "R9 dropped write not started", busy, 0);
    end
    check(bmem[60] == ref_mem[60], "R9 memory untouched", bmem[60], ref_mem[60]);
    do_read(6'd60, 1'b0, "R9");

    finish_run();
  end
endmodule